// File: doc/BRIEF.md
# Raster Sensor Readout Timing Generator

This block produces the pixel-clock-domain control timing for a raster image sensor with a Bayer colour mosaic. From a free-running pixel clock it derives a horizontal sync pulse, a frame sync pulse, a pixel-valid strobe, the row and column index of the pixel on the data bus, a two-bit colour-phase tag and a flag that marks dark reference lines. It produces no pixel data. It only says when data is present and what it is.

Each line starts with a programmable horizontal blank. A fixed tail follows: a guard band of blank clocks, a bordered span of pixels (active pixels with a border strip on each side), then a second guard band. Software programs the line length in units of two pixel clocks and the total number of lines per frame. Together these set the frame rate. Each frame opens with a dark line, then carries the image rows in bottom-to-top order, then a closing dark line. Any remaining lines up to the programmed count are vertical blanking. Both settings are clamped to legal ranges. They are captured only at a frame boundary, so a frame in flight is never reshaped.

With default parameters a line carries 640 active pixels inside a 2-pixel border on each side, with 4 guard clocks on each side of that span, and the shortest line is 772 clocks. A frame carries 484 image rows.

Top module: `sensor_raster_timing`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low, the generator sits at the first clock of the first line of a frame: `vsync` = 1, `hsync` = 1, `pix_valid` = 0. The first clock after release is that same position.
- R2: A line of L clocks starts with `hsync` high for L − TAIL clocks. TAIL = 2·GUARD + 2·BORDER + ACT_W, which is 652 with default parameters. Then come GUARD clocks with no valid pixel, then the pixel span of ACT_W + 2·BORDER clocks, then GUARD clocks with no valid pixel. `hsync` and `pix_valid` are never high together.
- R3: The line length L is twice the value of `line_len_half`. It is clamped below to LEAD + TAIL (772 by default) and above to MAX_LINE (1156 by default).
- R4: A frame has F lines. F is the value of `frame_lines`, clamped below to ACT_H + 2. Line 0 and line ACT_H + 1 are dark lines with `dark_line` high for their whole length. Lines 1..ACT_H are image lines. Lines after ACT_H + 1 carry neither valid pixels nor the dark flag.
- R5: `vsync` is high for every clock of line 0 of each frame and low for all other lines.
- R6: `pix_valid` is high only inside the pixel span of an image line, and it is high for all of that span. It is never high on a dark line or a blanking line.
- R7: During valid pixels `row_idx` is 0 on the first image line after the leading dark line (the bottom row) and rises by one per line. `col_idx` runs from 0 to ACT_W + 2·BORDER − 1, left to right, one step per clock.
- R8: During valid pixels `cfa_tag` = {row_idx[0], col_idx[0]}, encoded as 0 = blue, 1 = green on a blue row, 2 = green on a red row, 3 = red. Even rows therefore alternate B,G and odd rows alternate G,R.
- R9: Changes to `line_len_half` or `frame_lines` are ignored until the frame in progress ends. The next frame uses the values present on the last clock of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_len_half | input | LEN_W | Line length in units of two clocks |
| frame_lines | input | FR_W | Total lines per frame |
| hsync | output | 1 | High during the horizontal blank of each line |
| vsync | output | 1 | High for the whole first line of each frame |
| pix_valid | output | 1 | A pixel of an image line is on the bus |
| dark_line | output | 1 | The current line is a dark reference line |
| row_idx | output | RW | Image row of the current pixel, 0 at the bottom |
| col_idx | output | CW | Column of the current pixel within the bordered span |
| cfa_tag | output | 2 | Colour phase of the current pixel |

## Verification
A wrong horizontal count shows up within the same line. The `hsync` width, the offset of the first valid pixel, or the span length is then off on the very line that went wrong. A wrong vertical count or a setting captured at the wrong moment may stay hidden until the next `vsync`. That pulse then arrives early or late, or the next frame has the wrong line length. For that reason every line of several consecutive frames is measured, including frames where the inputs changed mid-frame. The colour tag and column index are compared pixel by pixel, so an off-by-one in the parity shows up on the first valid pixel of a line.

// File: rtl/sensor_raster_timing.sv
module sensor_raster_timing #(
  parameter int ACT_W    = 640,
  parameter int ACT_H    = 484,
  parameter int BORDER   = 2,
  parameter int GUARD    = 4,
  parameter int LEAD     = 120,
  parameter int MAX_LINE = 1156,
  parameter int FR_W     = 13,
  localparam int SPAN    = ACT_W + 2*BORDER,
  localparam int LEN_W   = $clog2(MAX_LINE/2 + 1),
  localparam int CW      = $clog2(SPAN),
  localparam int RW      = $clog2(ACT_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] line_len_half,
  input  logic [FR_W-1:0]  frame_lines,
  output logic             hsync,
  output logic             vsync,
  output logic             pix_valid,
  output logic             dark_line,
  output logic [RW-1:0]    row_idx,
  output logic [CW-1:0]    col_idx,
  output logic [1:0]       cfa_tag
);

  localparam int TAIL     = SPAN + 2*GUARD;
  localparam int MIN_LINE = LEAD + TAIL;
  localparam int MIN_FR   = ACT_H + 2;
  localparam int HW       = $clog2(MAX_LINE + 1);

  logic [HW-1:0]   h, cur_len, nxt_len, hb, span_lo;
  logic [FR_W-1:0] v, cur_fr, nxt_fr;
  logic [HW:0]     want_len;
  logic            line_end, frame_end, in_span, img_line;

  assign want_len = {{(HW-LEN_W){1'b0}}, line_len_half, 1'b0};
  assign nxt_len  = (want_len < (HW+1)'(MIN_LINE)) ? HW'(MIN_LINE) :
                    (want_len > (HW+1)'(MAX_LINE)) ? HW'(MAX_LINE) : want_len[HW-1:0];
  assign nxt_fr   = (frame_lines < FR_W'(MIN_FR)) ? FR_W'(MIN_FR) : frame_lines;

  assign line_end  = (h == cur_len - HW'(1));
  assign frame_end = line_end && (v == cur_fr - FR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h       <= '0;
      v       <= '0;
      cur_len <= nxt_len;
      cur_fr  <= nxt_fr;
    end else if (line_end) begin
      h <= '0;
      if (frame_end) begin
        v       <= '0;
        cur_len <= nxt_len;
        cur_fr  <= nxt_fr;
      end else begin
        v <= v + FR_W'(1);
      end
    end else begin
      h <= h + HW'(1);
    end
  end

  assign hb       = cur_len - HW'(TAIL);
  assign span_lo  = hb + HW'(GUARD);
  assign in_span  = (h >= span_lo) && (h < span_lo + HW'(SPAN));
  assign img_line = (v >= FR_W'(1)) && (v <= FR_W'(ACT_H));

  assign hsync     = (h < hb);
  assign vsync     = (v == '0);
  assign dark_line = (v == '0) || (v == FR_W'(ACT_H + 1));
  assign pix_valid = in_span && img_line;
  assign col_idx   = pix_valid ? CW'(h - span_lo) : '0;
  assign row_idx   = pix_valid ? RW'(v - FR_W'(1)) : '0;
  assign cfa_tag   = {row_idx[0], col_idx[0]};

  a_r2_sync_vs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !pix_valid);

  a_r5_vsync_on_dark: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> dark_line);

  a_r6_no_valid_on_dark: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !dark_line);

  a_r7_col_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && col_idx != CW'(SPAN-1)) |=> (pix_valid && col_idx == $past(col_idx) + CW'(1)));

  a_r7_span_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_valid) |-> $past(col_idx) == CW'(SPAN-1));

  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $past(v) == $past(cur_fr) - FR_W'(1));

  a_r9_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
    !(h == '0 && v == '0) |-> ($stable(cur_len) && $stable(cur_fr)));

endmodule

// File: tb/tb_sensor_raster_timing.sv
module tb_sensor_raster_timing;
  localparam int CLK_PERIOD = 10;
  localparam int ACT_W = 16, ACT_H = 6, BORDER = 2, GUARD = 4, LEAD = 8;
  localparam int MAX_LINE = 60, FR_W = 6;
  localparam int SPAN  = ACT_W + 2*BORDER;
  localparam int TAIL  = SPAN + 2*GUARD;
  localparam int LEN_W = $clog2(MAX_LINE/2 + 1);
  localparam int CW    = $clog2(SPAN);
  localparam int RW    = $clog2(ACT_H);

  typedef struct {
    int len; int hs; int off; int nval; int vs; int dk; int row;
  } line_t;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] line_len_half;
  logic [FR_W-1:0]  frame_lines;
  logic hsync, vsync, pix_valid, dark_line;
  logic [RW-1:0] row_idx;
  logic [CW-1:0] col_idx;
  logic [1:0] cfa_tag;

  int n_chk = 0, n_bad = 0;
  line_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_raster_timing #(.ACT_W(ACT_W), .ACT_H(ACT_H), .BORDER(BORDER), .GUARD(GUARD),
    .LEAD(LEAD), .MAX_LINE(MAX_LINE), .FR_W(FR_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_len_half(line_len_half), .frame_lines(frame_lines),
    .hsync(hsync), .vsync(vsync), .pix_valid(pix_valid), .dark_line(dark_line),
    .row_idx(row_idx), .col_idx(col_idx), .cfa_tag(cfa_tag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: pushes the expected line records of one frame with length L and F lines.
  task automatic push_frame(input int l, input int f);
    for (int v = 0; v < f; v++) begin
      line_t e;
      bit img = (v >= 1 && v <= ACT_H);
      e.len  = l;
      e.hs   = l - TAIL;
      e.off  = img ? l - TAIL + GUARD : 0;
      e.nval = img ? SPAN : 0;
      e.vs   = (v == 0) ? l : 0;
      e.dk   = (v == 0 || v == ACT_H + 1) ? l : 0;
      e.row  = img ? v - 1 : 0;
      expq.push_back(e);
    end
  endtask

  // Monitor
  line_t cur;
  bit active = 0, prev_hs = 0;

  task automatic finish_line();
    line_t e;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    check(cur.len  == e.len,  "R3 line length",        cur.len,  e.len);
    check(cur.hs   == e.hs,   "R2 hsync width",        cur.hs,   e.hs);
    check(cur.off  == e.off,  "R2 first valid offset", cur.off,  e.off);
    check(cur.nval == e.nval, "R6 valid count",        cur.nval, e.nval);
    check(cur.vs   == e.vs,   "R5 vsync clocks",       cur.vs,   e.vs);
    check(cur.dk   == e.dk,   "R4 dark clocks",        cur.dk,   e.dk);
    check(cur.row  == e.row,  "R7 row index",          cur.row,  e.row);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_hs = 0;
      active  = 0;
    end else begin
      if (hsync && !prev_hs) begin
        if (active) finish_line();
        active = 1;
        cur = '{default: 0};
      end
      if (pix_valid) begin
        if (cur.nval == 0) cur.off = cur.len;
        cur.row = int'(row_idx);
        check(int'(col_idx) == cur.nval, "R7 column index", int'(col_idx), cur.nval);
        check(cfa_tag == {row_idx[0], col_idx[0]}, "R8 colour tag", int'(cfa_tag),
              int'({row_idx[0], col_idx[0]}));
        cur.nval++;
      end
      if (hsync)     cur.hs++;
      if (vsync)     cur.vs++;
      if (dark_line) cur.dk++;
      cur.len++;
      prev_hs = hsync;
    end
  end

  initial begin
    line_len_half = LEN_W'(18);
    frame_lines   = FR_W'(8);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vsync == 1'b1 && hsync == 1'b1 && pix_valid == 1'b0, "R1 reset state",
          int'({vsync, hsync, pix_valid}), 6);
    rst_n = 1;
    push_frame(36, 8);
    repeat (100) @(posedge clk);
    line_len_half = LEN_W'(25); frame_lines = FR_W'(10);   // R9 mid-frame change
    push_frame(50, 10);
    repeat (388) @(posedge clk);
    line_len_half = LEN_W'(10); frame_lines = FR_W'(3);    // R3/R4 lower clamps
    push_frame(36, 8);
    repeat (400) @(posedge clk);
    line_len_half = LEN_W'(31); frame_lines = FR_W'(9);    // R3 upper clamp
    push_frame(60, 9);
    repeat (288) @(posedge clk);
    line_len_half = LEN_W'(22); frame_lines = FR_W'(12);   // R4 extra blanking lines
    push_frame(44, 12);
    repeat (540) @(posedge clk);
    line_len_half = LEN_W'(20); frame_lines = FR_W'(8);
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(posedge clk);
    check(expq.size() == 0, "R4 all lines seen", expq.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule